// File: doc/BRIEF.md
# Two-List Task Picker for a Shared-Memory Work Queue

This engine belongs to one processing element. It chooses the next task control block (TCB) that the element runs. Each TCB lives in shared memory as two consecutive words. Word 0 holds the link to the next TCB. Word 1 holds the address of the task's code. The engine looks after two head words:

- **Inbound list.** Any agent may push onto it. The newest entry is at the head.
- **Private list.** Only this engine touches it. The oldest entry is at the head.

When the private list has entries, the engine removes its head. When the private list is empty, the engine claims the whole inbound list with one atomic swap that writes zero into the inbound head. It then turns the claimed chain around in place. It hands out the oldest entry and stores the rest, now oldest-first, as the new private list. Producers never have to synchronise with the engine explicitly.

A producer links a TCB into the inbound list in two steps:
1. It sets the TCB's link word to all-ones.
2. It swaps the TCB address into the inbound head, then writes the real link.

The engine may therefore read an all-ones link. When it does, it reads the same word again until the real link appears. A "next task" request starts a pick. The result is presented as a TCB address and a code address under a valid/ready handshake. All addresses are word indices.

Top module: `taskq_dequeue`

## Requirements
- R1: After reset, `disp_valid` and `mem_req` are low. The engine touches no memory until `next_req` is seen high while the engine is idle.
- R2: If the private head word holds a non-zero address, the engine dispatches that TCB. It writes the TCB's link into the private head word and issues no swap.
- R3: If the private head word is zero, the engine swaps the value 0 into the inbound head word. It repeats the swap for as long as the returned value is 0. A swap (op code 2) is never aimed at any other address and never writes any other value.
- R4: Any link read that returns all-ones (16'hFFFF at the default width) is repeated on the same address until another value is returned. The engine never acts on an all-ones link.
- R5: If the claimed inbound chain holds a single TCB (its link is 0), that TCB is dispatched and the private head word stays 0.
- R6: If the claimed chain has two or more TCBs, the links are reversed in place. The oldest TCB is dispatched and the private head word receives the next-oldest address. Over any sequence of pushes, TCBs are dispatched in push order, and both head words are 0 once every pushed TCB has been dispatched.
- R7: A dispatch presents the TCB address on `disp_tcb` and the word at TCB address + 1 on `disp_code`. Both are held, with `disp_valid` high, until `disp_ready` is seen high.
- R8: A memory request (op 0 read, 1 write, 2 swap) keeps its op, address and write data stable until `mem_gnt` is high in the same cycle. Read and swap data are taken from `mem_rdata` in that cycle.
- R9: The engine never writes the all-ones sentinel value to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| priv_base | input | AW | Word address of the private list head |
| inbox_base | input | AW | Word address of the inbound list head |
| next_req | input | 1 | Start picking the next task (sampled when idle) |
| disp_valid | output | 1 | A picked task is presented |
| disp_ready | input | 1 | Consumer accepts the presented task |
| disp_tcb | output | AW | Address of the picked TCB |
| disp_code | output | AW | Code address read from TCB word 1 |
| mem_req | output | 1 | Memory access requested |
| mem_op | output | 2 | 0 read, 1 write, 2 atomic swap |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | AW | Write or swap data |
| mem_gnt | input | 1 | Access completes this cycle |
| mem_rdata | input | AW | Read data, or the old value for a swap, valid with the grant |

## Verification
The assertions assume the following about the engine's surroundings:
- A grant completes an access in its own cycle, with read data valid combinationally.
- Swaps are indivisible with respect to every other agent.
- No agent other than this engine ever writes the private head or a link word that is already linked.
- The head-word addresses are fixed while the engine is busy.

The bench's memory model applies every engine access and every producer action in a single process, between clock edges. This makes each swap and each producer push atomic. Producers follow the two-step protocol above: they set the link to all-ones, swap into the inbound head, and later write the true link after a delay of 0 to 4 cycles.

// File: rtl/taskq_dequeue.sv
module taskq_dequeue #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] priv_base,
  input  logic [AW-1:0] inbox_base,
  input  logic          next_req,
  output logic          disp_valid,
  input  logic          disp_ready,
  output logic [AW-1:0] disp_tcb,
  output logic [AW-1:0] disp_code,
  output logic          mem_req,
  output logic [1:0]    mem_op,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [AW-1:0] mem_rdata
);
  localparam logic [1:0]    OP_RD = 2'd0;
  localparam logic [1:0]    OP_WR = 2'd1;
  localparam logic [1:0]    OP_SW = 2'd2;
  localparam logic [AW-1:0] NIL   = '0;

  typedef enum logic [3:0] {
    S_IDLE, S_RPRIV, S_SWAP, S_RFIRST, S_WZERO, S_RNEXT,
    S_WREV, S_RTOP, S_WPRIV, S_RCODE, S_DISP
  } st_t;

  st_t           st;
  logic [AW-1:0] y, x, z, code;

  wire fire    = mem_req & mem_gnt;
  wire rd_nil  = (mem_rdata == NIL);
  wire rd_busy = &mem_rdata;

  assign mem_req    = (st != S_IDLE) && (st != S_DISP);
  assign disp_valid = (st == S_DISP);
  assign disp_tcb   = y;
  assign disp_code  = code;

  always_comb begin
    mem_op    = OP_RD;
    mem_addr  = NIL;
    mem_wdata = NIL;
    case (st)
      S_RPRIV:  mem_addr = priv_base;
      S_SWAP:   begin mem_op = OP_SW; mem_addr = inbox_base; end
      S_RFIRST: mem_addr = y;
      S_WZERO:  begin mem_op = OP_WR; mem_addr = y; end
      S_RNEXT:  mem_addr = x;
      S_WREV:   begin mem_op = OP_WR; mem_addr = x; mem_wdata = y; end
      S_RTOP:   mem_addr = y;
      S_WPRIV:  begin mem_op = OP_WR; mem_addr = priv_base; mem_wdata = x; end
      S_RCODE:  mem_addr = y + AW'(1);
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      y    <= NIL;
      x    <= NIL;
      z    <= NIL;
      code <= NIL;
    end else begin
      case (st)
        S_IDLE:  if (next_req) st <= S_RPRIV;
        S_RPRIV: if (fire) begin
          y  <= mem_rdata;
          st <= rd_nil ? S_SWAP : S_RTOP;
        end
        S_SWAP: if (fire && !rd_nil) begin
          y  <= mem_rdata;
          st <= S_RFIRST;
        end
        S_RFIRST: if (fire && !rd_busy) begin
          if (rd_nil) st <= S_RCODE;
          else begin
            x  <= mem_rdata;
            st <= S_WZERO;
          end
        end
        S_WZERO: if (fire) st <= S_RNEXT;
        S_RNEXT: if (fire && !rd_busy) begin
          z  <= mem_rdata;
          st <= S_WREV;
        end
        S_WREV: if (fire) begin
          y  <= x;
          x  <= (z == NIL) ? y : z;
          st <= (z == NIL) ? S_WPRIV : S_RNEXT;
        end
        S_RTOP: if (fire) begin
          x  <= mem_rdata;
          st <= S_WPRIV;
        end
        S_WPRIV: if (fire) st <= S_RCODE;
        S_RCODE: if (fire) begin
          code <= mem_rdata;
          st   <= S_DISP;
        end
        S_DISP:  if (disp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/taskq_dequeue_chk.sv
module taskq_dequeue_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] inbox_base,
  input logic          disp_valid,
  input logic          disp_ready,
  input logic [AW-1:0] disp_tcb,
  input logic [AW-1:0] disp_code,
  input logic          mem_req,
  input logic [1:0]    mem_op,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          mem_gnt
);
  p_req_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_op) && $stable(mem_wdata));

  p_disp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_tcb) && $stable(disp_code));

  p_swap_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_op == 2'd2 |-> mem_addr == inbox_base && mem_wdata == '0);

  p_no_sentinel_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_op == 2'd1 |-> mem_wdata != '1);

  p_disp_real_tcb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> disp_tcb != '0 && disp_tcb != '1);

  p_quiet_when_presenting_r1: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !mem_req);
endmodule

bind taskq_dequeue taskq_dequeue_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inbox_base(inbox_base),
  .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_tcb(disp_tcb), .disp_code(disp_code),
  .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_gnt(mem_gnt)
);

// File: tb/test_taskq_dequeue.sv
`timescale 1ns/1ps
module test_taskq_dequeue;
  localparam int AW = 16;
  localparam logic [15:0] PRIV  = 16'd2;
  localparam logic [15:0] INBOX = 16'd3;
  localparam logic [15:0] SENT  = 16'hFFFF;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, next_req, disp_valid, disp_ready, mem_req, mem_gnt;
  logic [15:0] disp_tcb, disp_code, mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_op;
  logic [15:0] mem [256];

  assign mem_rdata = mem[mem_addr[7:0]];

  taskq_dequeue #(.AW(AW)) i_taskq_dequeue (
    .clk(clk), .rst_n(rst_n), .priv_base(PRIV), .inbox_base(INBOX),
    .next_req(next_req), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_tcb(disp_tcb), .disp_code(disp_code), .mem_req(mem_req),
    .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  int tests = 0, fails = 0, cyc = 0, swaps = 0, sent_reads = 0;
  logic [7:0]  lfsr = 8'h5A;
  logic        rnd_gnt = 1'b0, rdy_next = 1'b0, req_next = 1'b0;
  logic        seen_v, prev_stall = 1'b0;
  logic [15:0] seen_t, seen_c, prev_addr;
  logic [15:0] fx_addr [8], fx_val [8];
  int          fx_cnt [8];
  logic [15:0] pu_addr [8];
  int          pu_cyc [8], pu_dly [8];
  logic        pu_on [8];

  function automatic logic [15:0] tcb_of(int k);
    return 16'(32 + 4 * k);
  endfunction

  function automatic logic [15:0] code_of(logic [15:0] a);
    return 16'hC000 | a;
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push_now(logic [15:0] a, int dly);
    logic [15:0] old;
    old = mem[INBOX[7:0]];
    mem[a[7:0] + 8'd1] = code_of(a);
    if (dly == 0) mem[a[7:0]] = old;
    else begin
      mem[a[7:0]] = SENT;
      for (int i = 0; i < 8; i++)
        if (fx_cnt[i] == 0) begin
          fx_addr[i] = a; fx_val[i] = old; fx_cnt[i] = dly;
          break;
        end
    end
    mem[INBOX[7:0]] = a;
  endtask

  task automatic step();
    logic acc;
    logic [1:0] aop;
    logic [15:0] aad, awd;
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_gnt = rnd_gnt ? (lfsr[0] | lfsr[2]) : 1'b1;
    disp_ready = rdy_next;
    next_req = req_next;
    seen_v = disp_valid; seen_t = disp_tcb; seen_c = disp_code;
    if (rst_n && prev_stall)
      check(mem_req && mem_addr == prev_addr, "R8 request held until grant", mem_addr, prev_addr);
    if (rst_n && mem_req && mem_op == 2'd1)
      check(mem_wdata != SENT, "R9 no sentinel write", mem_wdata, 16'h0000);
    acc = rst_n && mem_req && mem_gnt;
    aop = mem_op; aad = mem_addr; awd = mem_wdata;
    if (acc && aop == 2'd2) swaps++;
    if (acc && aop == 2'd0 && mem_rdata == SENT) sent_reads++;
    prev_stall = rst_n && mem_req && !mem_gnt;
    prev_addr = mem_addr;
    @(posedge clk);
    #1;
    cyc++;
    if (acc && aop != 2'd0) mem[aad[7:0]] = awd;
    for (int i = 0; i < 8; i++)
      if (fx_cnt[i] > 0) begin
        fx_cnt[i]--;
        if (fx_cnt[i] == 0) mem[fx_addr[i][7:0]] = fx_val[i];
      end
    for (int i = 0; i < 8; i++)
      if (pu_on[i] && cyc >= pu_cyc[i]) begin
        pu_on[i] = 1'b0;
        push_now(pu_addr[i], pu_dly[i]);
      end
  endtask

  task automatic get_task(output logic [15:0] t, output logic [15:0] c);
    int n;
    logic [15:0] ht, hc;
    req_next = 1'b1; rdy_next = 1'b0; n = 0;
    do begin step(); n++; end while (!seen_v && n < 5000);
    req_next = 1'b0;
    ht = seen_t; hc = seen_c;
    step();
    check(seen_v && seen_t == ht && seen_c == hc, "R7 dispatch held while not ready", seen_t, ht);
    rdy_next = 1'b1;
    step();
    rdy_next = 1'b0;
    t = ht; c = hc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] t, c;
    int s0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 8; i++) begin fx_cnt[i] = 0; pu_on[i] = 1'b0; end
    rst_n = 1'b0; mem_gnt = 1'b0; disp_ready = 1'b0; next_req = 1'b0;
    repeat (3) step();
    check(!disp_valid, "R1 disp_valid low in reset", {15'd0, disp_valid}, 16'd0);
    check(!mem_req, "R1 mem_req low in reset", {15'd0, mem_req}, 16'd0);
    rst_n = 1'b1;
    repeat (4) step();
    check(!mem_req && !disp_valid, "R1 idle without next_req", {15'd0, mem_req}, 16'd0);

    for (int mode = 0; mode < 2; mode++)
      for (int n = 1; n <= 6; n++) begin
        rnd_gnt = ((n + mode) % 2) == 1;
        if (mode == 0) begin
          for (int k = 0; k < n; k++) push_now(tcb_of(k), (k * 3 + n) % 5);
        end else begin
          for (int k = 0; k < n; k++) begin
            pu_addr[k] = tcb_of(k); pu_cyc[k] = cyc + 12 + 3 * k;
            pu_dly[k] = (k + n) % 4; pu_on[k] = 1'b1;
          end
        end
        s0 = swaps;
        get_task(t, c);
        check(t == tcb_of(0), "R6 oldest dispatched first", t, tcb_of(0));
        check(c == code_of(tcb_of(0)), "R7 code word from TCB+1", c, code_of(tcb_of(0)));
        if (mode == 1)
          check(swaps - s0 > 1, "R3 swap retried while inbound empty", 16'(swaps - s0), 16'd2);
        if (n == 1)
          check(mem[PRIV[7:0]] == 16'h0, "R5 single TCB leaves private head zero", mem[PRIV[7:0]], 16'h0);
        else if (mode == 0)
          check(mem[PRIV[7:0]] == tcb_of(1), "R6 private head is next-oldest", mem[PRIV[7:0]], tcb_of(1));
        for (int k = 1; k < n; k++) begin
          s0 = swaps;
          get_task(t, c);
          check(t == tcb_of(k), "R6 FIFO dispatch order", t, tcb_of(k));
          check(c == code_of(tcb_of(k)), "R7 code word from TCB+1", c, code_of(tcb_of(k)));
          if (mode == 0)
            check(swaps == s0, "R2 no swap while private list non-empty", 16'(swaps - s0), 16'd0);
        end
        repeat (6) step();
        check(mem[INBOX[7:0]] == 16'h0 && mem[PRIV[7:0]] == 16'h0, "R6 heads empty after drain",
              mem[INBOX[7:0]] | mem[PRIV[7:0]], 16'h0);
      end

    check(sent_reads > 0, "R4 sentinel links were re-read", 16'(sent_reads), 16'd1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule